// File: doc/BRIEF.md
# Interrupt Sense, Pending and Mask Unit

This block is the per-source front end of an interrupt controller. It accepts a bank of internal interrupt lines and eight external interrupt pins, decides for each source whether it is asserted according to its sense setting, and keeps a latched pending state for external pins that are set to edge sense. It then gates every source with its enable bit and presents a masked request vector to a downstream priority stage.

Only two senses exist: active-low level and high-to-low edge. Internal lines are always level-sensed. Each external pin can be switched to falling-edge sense. External pins pass through a two-flop synchronizer before any detection. Software uses a 32-bit word-addressed register port to set the enables, the sense selection and the test-force bits, to read the external pending state and to acknowledge latched edges. Within a source-indexed register, source n sits at bit 31-n.

Top module: `irq_sense_mask_unit`

## Requirements
- R1: After reset every register reads zero, no source is forced, all external pins are in level sense, and int_req and ext_req are all zero.
- R2: Internal source n is asserted while irq_int_n[n] is low, and int_req[n] is asserted AND its enable bit. Address 0 holds the enables for sources 0..31 and address 1 those for sources 32..63, with source n (mod 32) at bit 31-(n mod 32). A 1 enables and a 0 blocks.
- R3: Writing zero to an internal enable register blocks every source in it from the next cycle on, whatever their inputs or force bits.
- R4: A set force bit makes its source appear asserted regardless of the pin. Addresses 5 and 6 force internal sources 0..31 and 32..63, address 7 forces external pin p at bit 31-p. The external enables are at address 2, pin p at bit 31-p.
- R5: External pins go through a two-flop synchronizer. A level-sensed pin that goes low shows on ext_req after two rising edges and not after one.
- R6: At address 3, bit 15-p selects the sense of pin p (1 = falling edge, 0 = low level). All other bits read zero.
- R7: In edge sense a falling edge on pin p sets its pending bit (address 4, bit 31-p) even while the pin is disabled. ext_req[p] is pending AND enable, and the bit stays set after the pin returns high.
- R8: Writing address 4 clears each edge-pending bit whose data bit is 1. Bits written with 0 keep their value.
- R9: If a clear write and a new falling edge on the same pin are captured on the same clock edge, the pending bit stays set.
- R10: In level sense, the address 4 bit of a pin shows the synchronized pin state (1 while low). A write to address 4 does not remove a level request.
- R11: A rising edge on an edge-sensed pin does not set its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_int_n | input | 64 | Internal interrupt lines, active low |
| irq_ext_n | input | 8 | External interrupt pins, active low or falling edge |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| int_req | output | 64 | Masked requests of internal sources |
| ext_req | output | 8 | Masked requests of external pins |

## Verification
Two functions can coincide: a software acknowledge of an edge-pending bit, and a fresh falling edge on that same pin arriving on the clock edge that captures the write. The bench brings the synchronized edge to the detection point by counting the two synchronizer stages. It issues the acknowledge write so that it lands on exactly that edge, then reads the pending register and expects the bit to be still set. A plain acknowledge afterwards must clear it, so a design that lets the clear win, or one that never clears, is caught.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
    localparam int WORD_W    = 32;
    localparam int INT_WORDS = 2;
    localparam int INT_SRC   = INT_WORDS * WORD_W;
    localparam int EXT_PINS  = 8;
    localparam int SENSE_TOP = 15;

    localparam int A_MASK_INT0  = 0;
    localparam int A_MASK_EXT   = INT_WORDS;
    localparam int A_SENSE      = INT_WORDS + 1;
    localparam int A_PEND       = INT_WORDS + 2;
    localparam int A_FORCE_INT0 = INT_WORDS + 3;
    localparam int A_FORCE_EXT  = 2 * INT_WORDS + 3;
    localparam int ADDR_W       = $clog2(2 * INT_WORDS + 4);

    typedef struct packed {
        logic [INT_SRC-1:0]  mask_int;
        logic [EXT_PINS-1:0] mask_ext;
        logic [EXT_PINS-1:0] sense;
        logic [INT_SRC-1:0]  force_int;
        logic [EXT_PINS-1:0] force_ext;
    } cfg_t;

    // source index n <-> register bit WORD_W-1-n
    function automatic logic [WORD_W-1:0] msb_first(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) begin
            r[WORD_W-1-i] = v[i];
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_fe_sync.sv
module irq_fe_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    // idle level of an active-low pin is 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: '1, s2: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/irq_fe_ext_pend.sv
module irq_fe_ext_pend #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] edge_en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] pend;
    } pend_t;

    pend_t st_d, st_q;

    assign fall_o = st_q.prev & ~sync_i;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_i;
        // a new edge outranks an acknowledge in the same cycle
        st_d.pend = edge_en_i & ((st_q.pend & ~clr_i) | fall_o);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: '1, pend: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/irq_sense_mask_unit.sv
module irq_sense_mask_unit
    import irq_fe_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INT_SRC-1:0]  irq_int_n,
    input  logic [EXT_PINS-1:0] irq_ext_n,
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic [INT_SRC-1:0]  int_req,
    output logic [EXT_PINS-1:0] ext_req
);
    localparam int PAD_W = WORD_W - EXT_PINS;

    cfg_t                cfg_d, cfg_q;
    logic [WORD_W-1:0]   wrev;
    logic [EXT_PINS-1:0] sync_w;
    logic [EXT_PINS-1:0] pend_w;
    logic [EXT_PINS-1:0] fall_w;
    logic [EXT_PINS-1:0] clr_w;
    logic [EXT_PINS-1:0] sense_w;
    logic [EXT_PINS-1:0] ext_act;
    logic [EXT_PINS-1:0] pend_view;

    assign wrev    = msb_first(reg_wdata);
    assign sense_w = cfg_q.sense;

    irq_fe_sync #(.W(EXT_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_ext_n),
        .sync_o  (sync_w)
    );

    assign clr_w = (reg_wr_en && reg_addr == ADDR_W'(A_PEND)) ? wrev[EXT_PINS-1:0] : '0;

    irq_fe_ext_pend #(.W(EXT_PINS)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (sync_w),
        .edge_en_i (cfg_q.sense),
        .clr_i     (clr_w),
        .pend_o    (pend_w),
        .fall_o    (fall_w)
    );

    // configuration write decode
    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr_en) begin
            for (int w = 0; w < INT_WORDS; w++) begin
                if (reg_addr == ADDR_W'(A_MASK_INT0 + w)) begin
                    cfg_d.mask_int[w*WORD_W +: WORD_W] = wrev;
                end
                if (reg_addr == ADDR_W'(A_FORCE_INT0 + w)) begin
                    cfg_d.force_int[w*WORD_W +: WORD_W] = wrev;
                end
            end
            if (reg_addr == ADDR_W'(A_MASK_EXT)) begin
                cfg_d.mask_ext = wrev[EXT_PINS-1:0];
            end
            if (reg_addr == ADDR_W'(A_FORCE_EXT)) begin
                cfg_d.force_ext = wrev[EXT_PINS-1:0];
            end
            if (reg_addr == ADDR_W'(A_SENSE)) begin
                for (int p = 0; p < EXT_PINS; p++) begin
                    cfg_d.sense[p] = reg_wdata[SENSE_TOP-p];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // per-pin assertion view: latched edge or current low level
    assign pend_view = (cfg_q.sense & pend_w) | (~cfg_q.sense & ~sync_w);
    assign ext_act   = pend_view | cfg_q.force_ext;

    assign int_req = (~irq_int_n | cfg_q.force_int) & cfg_q.mask_int;
    assign ext_req = ext_act & cfg_q.mask_ext;

    // register read mux
    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < INT_WORDS; w++) begin
            if (reg_addr == ADDR_W'(A_MASK_INT0 + w)) begin
                reg_rdata = msb_first(cfg_q.mask_int[w*WORD_W +: WORD_W]);
            end
            if (reg_addr == ADDR_W'(A_FORCE_INT0 + w)) begin
                reg_rdata = msb_first(cfg_q.force_int[w*WORD_W +: WORD_W]);
            end
        end
        if (reg_addr == ADDR_W'(A_MASK_EXT)) begin
            reg_rdata = msb_first({{PAD_W{1'b0}}, cfg_q.mask_ext});
        end
        if (reg_addr == ADDR_W'(A_FORCE_EXT)) begin
            reg_rdata = msb_first({{PAD_W{1'b0}}, cfg_q.force_ext});
        end
        if (reg_addr == ADDR_W'(A_PEND)) begin
            reg_rdata = msb_first({{PAD_W{1'b0}}, pend_view});
        end
        if (reg_addr == ADDR_W'(A_SENSE)) begin
            for (int p = 0; p < EXT_PINS; p++) begin
                reg_rdata[SENSE_TOP-p] = cfg_q.sense[p];
            end
        end
    end
endmodule

// File: rtl/irq_sense_mask_chk.sv
module irq_sense_mask_chk
    import irq_fe_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr_en,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [WORD_W-1:0]   reg_wdata,
    input logic [INT_SRC-1:0]  int_req,
    input logic [EXT_PINS-1:0] pend,
    input logic [EXT_PINS-1:0] fall,
    input logic [EXT_PINS-1:0] clr,
    input logic [EXT_PINS-1:0] sense
);
    // R3: a zero write to the first enable register silences its sources
    assert_zero_mask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == ADDR_W'(A_MASK_INT0) && reg_wdata == '0)
        |=> (int_req[WORD_W-1:0] == '0));

    for (genvar p = 0; p < EXT_PINS; p++) begin : g_pin
        // R8: writing 0 to a set pending bit leaves it set
        assert_zero_write_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr_en && reg_addr == ADDR_W'(A_PEND) && !reg_wdata[WORD_W-1-p]
             && pend[p] && sense[p])
            |=> pend[p]);

        // R9: edge and acknowledge together leave the bit set
        assert_edge_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (fall[p] && clr[p] && sense[p]) |=> pend[p]);

        // R7: pending only rises after a detected falling edge
        assert_pend_from_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[p]) |-> $past(fall[p]));
    end
endmodule

bind irq_sense_mask_unit irq_sense_mask_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .int_req   (int_req),
    .pend      (pend_w),
    .fall      (fall_w),
    .clr       (clr_w),
    .sense     (sense_w)
);

// File: tb/irq_sense_mask_unit_test.sv
`timescale 1ns/1ps
module irq_sense_mask_unit_test;
    import irq_fe_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [INT_SRC-1:0]  irq_int_n = '1;
    logic [EXT_PINS-1:0] irq_ext_n = '1;
    logic                reg_wr_en = 1'b0;
    logic [ADDR_W-1:0]   reg_addr = '0;
    logic [WORD_W-1:0]   reg_wdata = '0;
    logic [WORD_W-1:0]   reg_rdata;
    logic [INT_SRC-1:0]  int_req;
    logic [EXT_PINS-1:0] ext_req;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    irq_sense_mask_unit uut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = ADDR_W'(a); #1; d = reg_rdata;
    endtask

    task automatic clocks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] sbit(input int n);
        return 32'h1 << (31 - n);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(a, d); chk("R1 reg", {32'b0, d}, 64'h0);
        end
        chk("R1 int_req", int_req, 64'h0);
        chk("R1 ext_req", {56'b0, ext_req}, 64'h0);
    endtask

    task automatic t_internal();
        logic [31:0] d;
        irq_int_n[3] = 1'b0; irq_int_n[40] = 1'b0;
        wr(0, sbit(3));
        chk("R2 src3 only", int_req, 64'h1 << 3);
        wr(1, sbit(8));
        chk("R2 src40", int_req, (64'h1 << 3) | (64'h1 << 40));
        rd(0, d); chk("R2 readback", {32'b0, d}, {32'b0, sbit(3)});
        irq_int_n[3] = 1'b1; #1;
        chk("R2 release", int_req, 64'h1 << 40);
        irq_int_n = '1;
        wr(1, 32'h0);
    endtask

    task automatic t_mask_zero();
        irq_int_n[0] = 1'b0; irq_int_n[17] = 1'b0;
        wr(0, 32'hFFFF_FFFF);
        chk("R3 enabled", int_req, (64'h1 << 0) | (64'h1 << 17));
        wr(0, 32'h0);
        chk("R3 zero write", int_req, 64'h0);
        irq_int_n = '1;
    endtask

    task automatic t_force();
        wr(5, sbit(5));
        chk("R4 force masked", int_req, 64'h0);
        wr(0, 32'hFFFF_FFFF);
        chk("R4 force int", int_req, 64'h1 << 5);
        wr(0, 32'h0); wr(5, 32'h0);
        wr(7, sbit(6)); wr(2, sbit(6));
        chk("R4 force ext", {56'b0, ext_req}, 64'h1 << 6);
        wr(7, 32'h0); wr(2, 32'h0);
        chk("R4 force off", {56'b0, ext_req}, 64'h0);
    endtask

    task automatic t_ext_level();
        logic [31:0] d;
        wr(2, 32'hFF00_0000);
        irq_ext_n[2] = 1'b0;
        clocks(1);
        chk("R5 one stage", {56'b0, ext_req}, 64'h0);
        clocks(1);
        chk("R5 two stages", {56'b0, ext_req}, 64'h1 << 2);
        rd(4, d); chk("R10 level view", {32'b0, d}, {32'b0, sbit(2)});
        wr(4, sbit(2));
        chk("R10 no ack needed", {56'b0, ext_req}, 64'h1 << 2);
        irq_ext_n[2] = 1'b1;
        clocks(2);
        chk("R10 level gone", {56'b0, ext_req}, 64'h0);
        wr(2, 32'h0);
    endtask

    task automatic t_sense_map();
        logic [31:0] d;
        wr(3, 32'hFFFF_FFFF);
        rd(3, d); chk("R6 unused bits", {32'b0, d}, 64'h0000_FF00);
        wr(3, 32'h0000_8100);
        rd(3, d); chk("R6 pins 0 and 7", {32'b0, d}, 64'h0000_8100);
        // pin 0 is edge, pin 7 edge: a fall on pin 0 latches
        irq_ext_n[0] = 1'b0; clocks(3); irq_ext_n[0] = 1'b1; clocks(3);
        rd(4, d); chk("R6 pin0 edge", {32'b0, d}, {32'b0, sbit(0)});
        wr(4, sbit(0));
        rd(4, d); chk("R8 clear pin0", {32'b0, d}, 64'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(3, 32'h0000_FF00);
        irq_ext_n[1] = 1'b0;
        clocks(3);
        rd(4, d); chk("R7 latched masked", {32'b0, d}, {32'b0, sbit(1)});
        chk("R7 masked no req", {56'b0, ext_req}, 64'h0);
        irq_ext_n[1] = 1'b1; clocks(3);
        wr(2, sbit(1));
        chk("R7 held and enabled", {56'b0, ext_req}, 64'h1 << 1);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(4, ~sbit(1));
        rd(4, d); chk("R8 zero keeps", {32'b0, d}, {32'b0, sbit(1)});
        wr(4, sbit(1));
        rd(4, d); chk("R8 one clears", {32'b0, d}, 64'h0);
        chk("R8 req gone", {56'b0, ext_req}, 64'h0);
        wr(2, 32'h0);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        irq_ext_n[4] = 1'b0; clocks(3);
        wr(4, sbit(4));
        rd(4, d); chk("R8 cleared pin4", {32'b0, d}, 64'h0);
        irq_ext_n[4] = 1'b1; clocks(4);
        rd(4, d); chk("R11 rise ignored", {32'b0, d}, 64'h0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        irq_ext_n[3] = 1'b0; clocks(3);
        irq_ext_n[3] = 1'b1; clocks(3);
        rd(4, d); chk("R9 pre set", {32'b0, d}, {32'b0, sbit(3)});
        irq_ext_n[3] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(4, sbit(3));
        rd(4, d); chk("R9 edge wins", {32'b0, d}, {32'b0, sbit(3)});
        wr(4, sbit(3));
        rd(4, d); chk("R9 later clear", {32'b0, d}, 64'h0);
        irq_ext_n[3] = 1'b1; clocks(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_internal();
        t_mask_zero();
        t_force();
        t_ext_level();
        t_sense_map();
        t_edge();
        t_w1c();
        t_rise();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule